// File: doc/BRIEF.md
# Flash Sector Update Sequencer

This block turns one request, "place these bytes at this flash address", into the full command sequence that a serial NOR flash needs to accept them. It sits above a command engine that handles chip select and bit shifting. The sequencer hands that engine one command at a time, as an opcode, a 24-bit address and a data byte count, and then waits for the engine's done pulse before it moves on.

An update runs in three phases. First, every sector that the byte range touches is erased, and each erase is preceded by its own write-enable command. Second, the range is programmed in pieces that never cross a page, and again each piece gets a write-enable first. Third, the whole range is read back in one stream, and each byte is compared with the source. After an erase or a program the sequencer waits a fixed time instead of polling status. After any other command it keeps a minimum idle gap. Source bytes are fetched by offset from a user buffer, so the same buffer serves both programming and verification.

Top module: `flash_update_seq`

## Requirements
- R1: A start is accepted only while `usr_busy` is low. `usr_busy` is high from the cycle after acceptance through the cycle in which `usr_done` is high. A start that arrives while busy changes nothing in the command stream.
- R2: Every sector-erase command (opcode 0xD8) and every page-program command (opcode 0x02) comes directly after a completed write-enable command (opcode 0x06), with no other command in between.
- R3: For each sector of 2^SECT_LG bytes that the range [addr, addr+len) touches, in ascending order, the block issues one erase whose address is aligned to the sector. All erases come before the first program.
- R4: Program commands cover the range in ascending order with no gaps. Each one has a byte count of at least 1 and ends at or before the next 2^PAGE_LG page boundary, and each one is as long as the page and the remaining length allow.
- R5: The next command start comes no earlier than ERASE_WAIT cycles after the cycle that carries the done of an erase, and no earlier than PROG_WAIT cycles after the done of a program.
- R6: After a write-enable or a read completes, at least CS_GAP idle cycles pass before the next command starts. This also holds across the end of one update and the start of the next.
- R7: During a program, the byte the block gives on `cmd_wdata` for each `cmd_wr_req` is the source byte at `src_idx`. `src_idx` moves through the offsets of the range in order.
- R8: The verify is a single read (opcode 0x03) at the base address with the full length. If any byte on `cmd_rdata` differs from the matching source byte, `usr_err` is high when `usr_done` pulses. Otherwise `usr_err` is low.
- R9: `usr_done` is a one-cycle pulse that comes CS_GAP+1 cycles after the cycle carrying the verify's done. `usr_err` keeps its value until the next accepted start clears it.
- R10: A start with length 0 issues no command and gives `usr_done` in the cycle after acceptance, with `usr_err` low.
- R11: While reset is held and after it is released, `usr_busy`, `usr_done`, `usr_err` and `cmd_start` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usr_start | input | 1 | Request an update (taken while idle) |
| usr_addr | input | ADDR_W | Flash address of the first byte |
| usr_len | input | LEN_W | Number of bytes to write |
| usr_busy | output | 1 | An update is in progress |
| usr_done | output | 1 | One-cycle completion pulse |
| usr_err | output | 1 | Read-back mismatch seen in the last update |
| src_idx | output | LEN_W | Offset of the source byte wanted now |
| src_data | input | 8 | Source byte at `src_idx`, combinational |
| cmd_start | output | 1 | One-cycle command launch to the engine |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | ADDR_W | Command address |
| cmd_len | output | LEN_W | Data byte count of the command |
| cmd_wdata | output | 8 | Data byte for the engine during a program |
| cmd_wr_req | input | 1 | Engine takes one program byte this cycle |
| cmd_rd_vld | input | 1 | Engine delivers one read byte this cycle |
| cmd_rdata | input | 8 | Read byte from the engine |
| cmd_done | input | 1 | Engine finished the current command |

## Verification
The bench goes after ranges that start in the middle of a page and cross pages and a sector. A sequencer that split on the wrong boundary would issue a program that wraps inside the page and corrupts earlier bytes. A full aligned page checks that the piece length does not come out as 0 or 256+. A flash model that begins all-zero and drops a bit at one chosen address makes a skipped erase or a corrupted byte show up as a verify mismatch, which is then flagged. A stray start in the middle of a run, a zero-length request, and back-to-back updates test that the block does not restart, hang, or squeeze the chip-select gap between two updates.

// File: rtl/flash_update_seq.sv
module flash_update_seq #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 17,
  parameter int PAGE_LG    = 8,
  parameter int SECT_LG    = 16,
  parameter int CNT_W      = 32,
  parameter int ERASE_WAIT = 35_000_000,
  parameter int PROG_WAIT  = 350_000,
  parameter int CS_GAP     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usr_start,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic [LEN_W-1:0]  usr_len,
  output logic              usr_busy,
  output logic              usr_done,
  output logic              usr_err,
  output logic [LEN_W-1:0]  src_idx,
  input  logic [7:0]        src_data,
  output logic              cmd_start,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [7:0]        cmd_wdata,
  input  logic              cmd_wr_req,
  input  logic              cmd_rd_vld,
  input  logic [7:0]        cmd_rdata,
  input  logic              cmd_done
);
  localparam int PAGE = 1 << PAGE_LG;
  localparam logic [7:0] OP_WREN = 8'h06, OP_SE = 8'hD8, OP_PP = 8'h02, OP_RD = 8'h03;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_GAP, S_FIN} ph_t;
  typedef enum logic [2:0] {K_WEE, K_ERASE, K_WEP, K_PROG, K_READ} step_t;

  ph_t               ph;
  step_t             step;
  logic [ADDR_W-1:0] base, es_addr, pg_addr;
  logic [LEN_W-1:0]  len, rem, off;
  logic [CNT_W-1:0]  cnt;
  logic              err;

  wire [PAGE_LG:0]  room    = (PAGE_LG+1)'(PAGE) - {1'b0, pg_addr[PAGE_LG-1:0]};
  wire [LEN_W-1:0]  chunk   = (rem < LEN_W'(room)) ? rem : LEN_W'(room);
  wire [ADDR_W:0]   end_a   = {1'b0, base} + (ADDR_W+1)'(len);
  wire [ADDR_W:0]   nxt_sec = {({1'b0, es_addr[ADDR_W-1:SECT_LG]} + 1'b1), {SECT_LG{1'b0}}};
  wire [CNT_W-1:0]  hold    = (step == K_ERASE) ? CNT_W'(ERASE_WAIT) :
                              (step == K_PROG)  ? CNT_W'(PROG_WAIT)  : CNT_W'(CS_GAP);

  assign usr_busy  = (ph != S_IDLE);
  assign usr_done  = (ph == S_FIN);
  assign usr_err   = err;
  assign src_idx   = off;
  assign cmd_wdata = src_data;
  assign cmd_start = (ph == S_ISSUE);

  always_comb begin
    cmd_op   = OP_WREN;
    cmd_addr = '0;
    cmd_len  = '0;
    case (step)
      K_ERASE: begin cmd_op = OP_SE; cmd_addr = es_addr; end
      K_PROG:  begin cmd_op = OP_PP; cmd_addr = pg_addr; cmd_len = chunk; end
      K_READ:  begin cmd_op = OP_RD; cmd_addr = base;    cmd_len = len;   end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE; step <= K_WEE; base <= '0; es_addr <= '0; pg_addr <= '0;
      len <= '0; rem <= '0; off <= '0; cnt <= '0; err <= 1'b0;
    end else begin
      case (ph)
        S_IDLE: if (usr_start) begin
          base    <= usr_addr;
          len     <= usr_len;
          rem     <= usr_len;
          pg_addr <= usr_addr;
          es_addr <= {usr_addr[ADDR_W-1:SECT_LG], {SECT_LG{1'b0}}};
          off     <= '0;
          err     <= 1'b0;
          step    <= K_WEE;
          ph      <= (usr_len == '0) ? S_FIN : S_ISSUE;
        end
        S_ISSUE: ph <= S_WAIT;
        S_WAIT: begin
          if (cmd_wr_req) off <= off + 1'b1;
          if (cmd_rd_vld) begin
            if (cmd_rdata != src_data) err <= 1'b1;
            off <= off + 1'b1;
          end
          if (cmd_done) begin
            cnt <= hold;
            ph  <= S_GAP;
          end
        end
        S_GAP: if (cnt <= CNT_W'(1)) begin
          ph <= S_ISSUE;
          case (step)
            K_WEE:   step <= K_ERASE;
            K_ERASE: if (nxt_sec < end_a) begin
                       es_addr <= nxt_sec[ADDR_W-1:0];
                       step    <= K_WEE;
                     end else step <= K_WEP;
            K_WEP:   step <= K_PROG;
            K_PROG: begin
              pg_addr <= pg_addr + ADDR_W'(chunk);
              rem     <= rem - chunk;
              if (rem == chunk) begin step <= K_READ; off <= '0; end
              else step <= K_WEP;
            end
            default: ph <= S_FIN;
          endcase
        end else cnt <= cnt - 1'b1;
        default: ph <= S_IDLE;
      endcase
    end
  end

  logic [7:0]       last_op;
  logic [CNT_W-1:0] since, need;
  logic             pp_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op <= '0; since <= '1; need <= '0; pp_seen <= 1'b0;
    end else begin
      if (cmd_start) last_op <= cmd_op;
      if (cmd_done) begin
        since <= '0;
        need  <= (last_op == OP_SE) ? CNT_W'(ERASE_WAIT) :
                 (last_op == OP_PP) ? CNT_W'(PROG_WAIT) : CNT_W'(CS_GAP);
      end else if (since != '1) since <= since + 1'b1;
      if (cmd_start && cmd_op == OP_PP) pp_seen <= 1'b1;
      else if (usr_done) pp_seen <= 1'b0;
    end
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    usr_start && !usr_busy |=> usr_busy);
  p_wren_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && (cmd_op == OP_SE || cmd_op == OP_PP) |-> last_op == OP_WREN);
  p_erase_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && cmd_op == OP_SE |-> !pp_seen && cmd_addr[SECT_LG-1:0] == '0);
  p_page_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && cmd_op == OP_PP |-> cmd_len != '0 &&
    (LEN_W+1)'(cmd_addr[PAGE_LG-1:0]) + (LEN_W+1)'(cmd_len) <= (LEN_W+1)'(PAGE));
  p_busy_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && (last_op == OP_SE || last_op == OP_PP) |-> since >= need);
  p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && (last_op == OP_WREN || last_op == OP_RD) |-> since >= CNT_W'(CS_GAP));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |=> !usr_done && !usr_busy);
  p_empty_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    usr_start && !usr_busy && usr_len == '0 |=> usr_done && !cmd_start);
endmodule

// File: tb/tb_flash_update_seq.sv
`timescale 1ns/1ps
module tb_flash_update_seq;
  localparam int AW = 24, LW = 12, PLG = 4, SLG = 6;
  localparam int EW = 40, PW = 20, GAP = 10;
  localparam int PAGE = 1 << PLG, SECT = 1 << SLG;

  logic clk = 0, rst_n = 0;
  logic usr_start = 0;
  logic [AW-1:0] usr_addr = '0;
  logic [LW-1:0] usr_len = '0;
  logic usr_busy, usr_done, usr_err;
  logic [LW-1:0] src_idx;
  logic [7:0] src_data;
  logic cmd_start;
  logic [7:0] cmd_op, cmd_wdata;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic cmd_wr_req = 0, cmd_rd_vld = 0, cmd_done = 0;
  logic [7:0] cmd_rdata = '0;

  always #10 clk = ~clk;

  logic [7:0] srcbuf [0:255];
  logic [7:0] flash [0:1023];
  assign src_data = srcbuf[src_idx[7:0]];

  flash_update_seq #(.ADDR_W(AW), .LEN_W(LW), .PAGE_LG(PLG), .SECT_LG(SLG),
    .CNT_W(16), .ERASE_WAIT(EW), .PROG_WAIT(PW), .CS_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .usr_start(usr_start), .usr_addr(usr_addr),
    .usr_len(usr_len), .usr_busy(usr_busy), .usr_done(usr_done), .usr_err(usr_err),
    .src_idx(src_idx), .src_data(src_data), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
    .cmd_wr_req(cmd_wr_req), .cmd_rd_vld(cmd_rd_vld), .cmd_rdata(cmd_rdata),
    .cmd_done(cmd_done));

  int checks = 0, errors = 0;
  bit finished = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int q_op[$], q_addr[$], q_len[$];
  int cyc = 0, last_done = -1000, last_op = -1, exp_done_cyc = -10;
  int e_mode = 0, e_cnt = 0, e_op = 0, e_addr = 0, e_len = 0, e_i = 0;
  int vbase = 0, bad_addr = -1;
  bit exp_busy = 0, exp_err = 0, p_start = 0, p_busy = 0;
  int p_len = 0;

  always @(negedge clk) begin
    cyc++;
    cmd_done = 0; cmd_wr_req = 0; cmd_rd_vld = 0;
    if (rst_n) begin
      if (cyc == exp_done_cyc + 1) exp_busy = 0;
      if (p_start && !p_busy) begin
        exp_busy = 1;
        exp_err = 0;
        chk(usr_err == 1'b0, "R9 err cleared on start", usr_err, 0);
        if (p_len == 0) exp_done_cyc = cyc;
      end
      chk(usr_busy == exp_busy, "R1 busy", usr_busy, exp_busy);
      chk(usr_done == (cyc == exp_done_cyc), "R9 done timing", usr_done, cyc == exp_done_cyc);
      if (cyc == exp_done_cyc)
        chk(usr_err == exp_err, "R8 error flag at done", usr_err, exp_err);
      p_busy = exp_busy; p_start = usr_start; p_len = int'(usr_len);

      if (cmd_start) begin
        chk(e_mode == 0, "R2 command overlap", e_mode, 0);
        if (q_op.size() == 0) chk(0, "R10 unexpected command", cmd_op, -1);
        else begin
          chk(cmd_op == q_op[0], "R2 R3 R4 opcode order", cmd_op, q_op[0]);
          chk(cmd_addr == q_addr[0], "R3 R4 R8 address", cmd_addr, q_addr[0]);
          chk(cmd_len == q_len[0], "R4 R8 length", cmd_len, q_len[0]);
          void'(q_op.pop_front()); void'(q_addr.pop_front()); void'(q_len.pop_front());
        end
        if (last_op == 8'hD8) chk(cyc - last_done - 1 >= EW, "R5 erase wait", cyc - last_done - 1, EW);
        else if (last_op == 8'h02) chk(cyc - last_done - 1 >= PW, "R5 program wait", cyc - last_done - 1, PW);
        else if (last_op >= 0) chk(cyc - last_done - 1 >= GAP, "R6 select gap", cyc - last_done - 1, GAP);
        e_op = cmd_op; e_addr = cmd_addr; e_len = cmd_len; e_i = 0;
        case (cmd_op)
          8'h06: begin e_mode = 1; e_cnt = 3; end
          8'hD8: begin
            for (int i = 0; i < SECT; i++) flash[(e_addr + i) % 1024] = 8'hFF;
            e_mode = 1; e_cnt = 4;
          end
          8'h02: e_mode = 2;
          default: e_mode = 3;
        endcase
      end else begin
        case (e_mode)
          1: begin
            e_cnt--;
            if (e_cnt == 0) begin cmd_done = 1; e_mode = 0; last_done = cyc; last_op = e_op; end
          end
          2: if (e_i < e_len) begin
            cmd_wr_req = 1;
            chk(cmd_wdata == srcbuf[e_addr + e_i - vbase], "R7 program data", cmd_wdata,
                srcbuf[e_addr + e_i - vbase]);
            flash[(e_addr + e_i) % 1024] = flash[(e_addr + e_i) % 1024] & cmd_wdata &
              (((e_addr + e_i) == bad_addr) ? 8'hFE : 8'hFF);
            e_i++;
          end else begin cmd_done = 1; e_mode = 0; last_done = cyc; last_op = e_op; end
          3: if (e_i < e_len) begin
            cmd_rd_vld = 1;
            cmd_rdata = flash[(e_addr + e_i) % 1024];
            if (cmd_rdata != srcbuf[e_i]) exp_err = 1;
            e_i++;
          end else begin
            cmd_done = 1; e_mode = 0; last_done = cyc; last_op = e_op;
            exp_done_cyc = cyc + GAP + 1;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic run(input int base, input int len, input int seed, input bit want_err,
                     input bit poke);
    vbase = base;
    for (int i = 0; i < 256; i++) srcbuf[i] = 8'((i * 29 + seed) | 1);
    if (len > 0) begin
      for (int s = base >> SLG; s <= (base + len - 1) >> SLG; s++) begin
        q_op.push_back(8'h06); q_addr.push_back(0); q_len.push_back(0);
        q_op.push_back(8'hD8); q_addr.push_back(s << SLG); q_len.push_back(0);
      end
      for (int a = base, r = len; r > 0; ) begin
        int n;
        n = PAGE - (a % PAGE);
        if (r < n) n = r;
        q_op.push_back(8'h06); q_addr.push_back(0); q_len.push_back(0);
        q_op.push_back(8'h02); q_addr.push_back(a); q_len.push_back(n);
        a += n; r -= n;
      end
      q_op.push_back(8'h03); q_addr.push_back(base); q_len.push_back(len);
    end
    @(posedge clk); #2;
    usr_start = 1; usr_addr = AW'(base); usr_len = LW'(len);
    @(posedge clk); #2;
    usr_start = 0;
    if (poke) begin
      repeat (30) @(posedge clk);
      #2 usr_start = 1; usr_addr = AW'(700); usr_len = LW'(5);
      @(posedge clk); #2 usr_start = 0;
    end
    @(negedge clk);
    while (!usr_done) @(negedge clk);
    chk(usr_err == want_err, want_err ? "R8 mismatch flagged" : "R8 clean verify", usr_err, want_err);
    chk(q_op.size() == 0, "R3 R4 all commands issued", q_op.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) flash[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!usr_busy && !usr_done && !usr_err && !cmd_start, "R11 reset outputs",
        {usr_busy, usr_done, usr_err, cmd_start}, 0);
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    chk(!usr_busy && !cmd_start, "R11 idle after reset", {usr_busy, cmd_start}, 0);
    run(0, 1, 3, 0, 0);
    run(60, 40, 11, 0, 0);
    run(32, 16, 5, 0, 0);
    run(0, 0, 1, 0, 0);
    bad_addr = 133;
    run(128, 20, 7, 1, 0);
    bad_addr = -1;
    run(200, 23, 9, 0, 1);
    run(64, 0, 2, 0, 0);
    chk(usr_err == 1'b0, "R10 empty run leaves error low", usr_err, 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule